// File: doc/BRIEF.md
# DDR SDRAM Bank State and Command Timing Tracker

This block sits next to a DDR SDRAM command scheduler and tracks four banks. It watches the stream of decoded commands and their bank select, one command per clock. From that stream it keeps each bank in one of four conditions: closed, open, busy with an ordinary burst, or locked by an auto-precharge burst and its recovery. Each condition has its own countdown. The scheduler reads two permission masks back each cycle. One mask says which banks may take a column access (read or write). The other says which banks may take a precharge. These masks let the scheduler pick only legal commands.

The burst length and CAS latency come from mode inputs. These are set while the block is held in reset and stay fixed afterwards. A read strobe marks the cycle in which the first read data is due. An ordinary precharge may cut a normal burst short. An auto-precharge access cannot be interrupted: its bank refuses every command until it has closed by itself. A command that breaks a rule leaves all bank state as it was and sets a sticky error flag. Data strobe generation, data capture and refresh scheduling belong to other blocks.

Top module: `ddr_bank_tracker`

## Requirements
- R1: After reset every bank is closed: `mayRdWr` is 4'b0000, `mayPre` is 4'b1111, and `rdDataDue` and `cmdErr` are low.
- R2: An activate (`cmdOp`=1) to a closed bank opens it. The bank's `mayRdWr` bit goes high exactly T_RCD cycles after the activate cycle and stays low before that.
- R3: A legal read (`cmdOp`=2) or read with auto-precharge (`cmdOp`=4) issued in cycle t raises `rdDataDue` for one cycle in cycle t+CL. CL is `modeCasLat`, clamped to the range 1..MAX_CAS.
- R4: A legal plain read or write (`cmdOp`=2 or 3) occupies its bank for B cycles, with B equal to half the burst length. `modeBurstLen` 2'b01 gives B=1, 2'b10 gives B=2, 2'b11 gives B=4, and 2'b00 is treated as 2'b01. The bank's `mayRdWr` is low from t+1 until t+B and high again in cycle t+B.
- R5: A precharge (`cmdOp`=6) to an open bank closes it in the next cycle, even in the middle of a plain burst. After that, an activate to the bank is legal.
- R6: A legal read or write with auto-precharge (`cmdOp`=4 or 5) in cycle t clears both `mayRdWr` and `mayPre` for that bank from t+1 until t+B+T_APR. In that cycle the bank is closed, and no command changes it before then.
- R7: A precharge-all (`cmdOp`=7) closes every bank that is not locked by auto-precharge. Locked banks keep their lock, and the command never raises `cmdErr`.
- R8: An illegal command leaves every bank unchanged and sets `cmdErr` in the next cycle. The illegal commands are: an activate to a bank that is not closed, a column access to a bank whose `mayRdWr` is low, and a precharge to a locked bank. `cmdErr` then stays high until reset.
- R9: A precharge to a closed bank is legal and has no effect.
- R10: `cmdOp` 0 is a no-operation. It changes no bank state and does not affect `cmdErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdOp | input | 3 | Decoded command, encoded as in R2 to R10 |
| cmdBank | input | 2 | Bank addressed by the command |
| modeCasLat | input | 3 | CAS latency in cycles, held constant after reset |
| modeBurstLen | input | 2 | Burst length code (R4), held constant after reset |
| mayRdWr | output | 4 | Per-bank permission for a read or write |
| mayPre | output | 4 | Per-bank permission for a precharge |
| rdDataDue | output | 1 | First read data is due this cycle |
| cmdErr | output | 1 | Sticky protocol violation flag |

## Verification
The hardest case to reach from the ports is a precharge-all that arrives while one bank is locked by auto-precharge and another bank is in the middle of a plain burst. To get there, two banks must be activated back to back. Once both have cleared T_RCD, the stimulus issues an auto-precharge read to one bank and a plain read to the other, then sends the precharge-all inside the lock window. Randomised command streams under each burst length code and several CAS latencies add overlapping read strobes and illegal commands. A behavioural model tracks every cycle against these streams.

// File: rtl/ddr_trk_pkg.sv
`timescale 1ns/1ps
package ddr_trk_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_RDA  = 3'd4,
    OP_WRA  = 3'd5,
    OP_PRE  = 3'd6,
    OP_PREA = 3'd7
  } cmdOp_t;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_BURST = 2'd2,
    BK_LOCK  = 2'd3
  } bankState_t;

  // strobes from the command checker into the state/timer datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] act;
    logic [NUM_BANKS-1:0] xfer;
    logic [NUM_BANKS-1:0] xferAp;
    logic [NUM_BANKS-1:0] close;
    logic                 rdLaunch;
    logic                 flagErr;
  } trkStrobe_t;
endpackage

// File: rtl/ddr_trk_ctrl.sv
`timescale 1ns/1ps
module ddr_trk_ctrl
  import ddr_trk_pkg::*;
(
  input  logic [2:0]           cmdOp,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic [NUM_BANKS-1:0] bankIdle,
  input  logic [NUM_BANKS-1:0] bankMayRdWr,
  input  logic [NUM_BANKS-1:0] bankMayPre,
  output trkStrobe_t           stb
);
  cmdOp_t               op;
  logic [NUM_BANKS-1:0] sel;

  always_comb begin
    op  = cmdOp_t'(cmdOp);
    sel = '0;
    sel[cmdBank] = 1'b1;
  end

  always_comb begin
    stb = '0;
    unique case (op)
      OP_ACT: begin
        if (bankIdle[cmdBank]) stb.act = sel;
        else                   stb.flagErr = 1'b1;
      end
      OP_RD, OP_WR, OP_RDA, OP_WRA: begin
        if (bankMayRdWr[cmdBank]) begin
          if (op == OP_RD || op == OP_WR) stb.xfer   = sel;
          else                            stb.xferAp = sel;
          stb.rdLaunch = (op == OP_RD) || (op == OP_RDA);
        end else begin
          stb.flagErr = 1'b1;
        end
      end
      OP_PRE: begin
        if (bankMayPre[cmdBank]) stb.close   = sel;
        else                     stb.flagErr = 1'b1;
      end
      OP_PREA: stb.close = bankMayPre;
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_trk_bank.sv
`timescale 1ns/1ps
module ddr_trk_bank
  import ddr_trk_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_APR = 2,
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act,
  input  logic       xfer,
  input  logic       xferAp,
  input  logic       close,
  input  logic [3:0] beats,
  output logic       isIdle,
  output logic       mayRdWr,
  output logic       mayPre
);
  localparam logic [CNT_W-1:0] RCD_LOAD  = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] APR_EXTRA = CNT_W'(T_APR - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  bankState_t       state;
  logic [CNT_W-1:0] rcdCnt;
  logic [CNT_W-1:0] busyCnt;
  logic [CNT_W-1:0] beatsW;

  assign beatsW = CNT_W'(beats);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= BK_IDLE;
      rcdCnt  <= '0;
      busyCnt <= '0;
    end else if (act) begin
      state  <= BK_OPEN;
      rcdCnt <= RCD_LOAD;
    end else if (close && state != BK_LOCK) begin
      state   <= BK_IDLE;
      rcdCnt  <= '0;
      busyCnt <= '0;
    end else if (xfer) begin
      if (beatsW == ONE) begin
        state <= BK_OPEN;
      end else begin
        state   <= BK_BURST;
        busyCnt <= beatsW - ONE;
      end
    end else if (xferAp) begin
      state   <= BK_LOCK;
      busyCnt <= beatsW + APR_EXTRA;
    end else begin
      if (rcdCnt != '0) rcdCnt <= rcdCnt - ONE;
      if (state == BK_BURST || state == BK_LOCK) begin
        if (busyCnt == ONE) state <= (state == BK_LOCK) ? BK_IDLE : BK_OPEN;
        busyCnt <= busyCnt - ONE;
      end
    end
  end

  assign isIdle  = (state == BK_IDLE);
  assign mayRdWr = (state == BK_OPEN) && (rcdCnt == '0);
  assign mayPre  = (state != BK_LOCK);
endmodule

// File: rtl/ddr_trk_datapath.sv
`timescale 1ns/1ps
module ddr_trk_datapath
  import ddr_trk_pkg::*;
#(
  parameter int T_RCD   = 3,
  parameter int T_APR   = 2,
  parameter int MAX_CAS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  trkStrobe_t           stb,
  input  logic [1:0]           modeBurstLen,
  input  logic [2:0]           modeCasLat,
  output logic [NUM_BANKS-1:0] bankIdle,
  output logic [NUM_BANKS-1:0] mayRdWr,
  output logic [NUM_BANKS-1:0] mayPre,
  output logic                 rdDataDue,
  output logic                 cmdErr
);
  localparam int CNT_W = $clog2(T_RCD + T_APR + 5);
  localparam int IDX_W = $clog2(MAX_CAS);

  logic [3:0]         beats;
  logic [MAX_CAS-1:0] rdPipe;
  logic [IDX_W-1:0]   casIdx;

  always_comb begin
    unique case (modeBurstLen)
      2'b10:   beats = 4'd2;
      2'b11:   beats = 4'd4;
      default: beats = 4'd1;
    endcase
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ddr_trk_bank #(.T_RCD(T_RCD), .T_APR(T_APR), .CNT_W(CNT_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (stb.act[b]),
        .xfer   (stb.xfer[b]),
        .xferAp (stb.xferAp[b]),
        .close  (stb.close[b]),
        .beats  (beats),
        .isIdle (bankIdle[b]),
        .mayRdWr(mayRdWr[b]),
        .mayPre (mayPre[b])
      );
    end
  endgenerate

  // read launch travels one stage per cycle; the tap picks the latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdPipe <= '0;
    end else begin
      rdPipe[0] <= stb.rdLaunch;
      for (int i = 1; i < MAX_CAS; i++) rdPipe[i] <= rdPipe[i-1];
    end
  end

  always_comb begin
    if (modeCasLat == 3'd0)                 casIdx = '0;
    else if (int'(modeCasLat) > MAX_CAS)    casIdx = IDX_W'(MAX_CAS - 1);
    else                                    casIdx = IDX_W'(int'(modeCasLat) - 1);
  end

  assign rdDataDue = rdPipe[casIdx];

  always_ff @(posedge clk) begin
    if (!rst_n)           cmdErr <= 1'b0;
    else if (stb.flagErr) cmdErr <= 1'b1;
  end
endmodule

// File: rtl/ddr_bank_tracker.sv
`timescale 1ns/1ps
module ddr_bank_tracker #(
  parameter int T_RCD   = 3,
  parameter int T_APR   = 2,
  parameter int MAX_CAS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmdOp,
  input  logic [1:0] cmdBank,
  input  logic [2:0] modeCasLat,
  input  logic [1:0] modeBurstLen,
  output logic [3:0] mayRdWr,
  output logic [3:0] mayPre,
  output logic       rdDataDue,
  output logic       cmdErr
);
  import ddr_trk_pkg::*;

  trkStrobe_t stb;
  logic [3:0] bankIdle;

  ddr_trk_ctrl u_ctrl (
    .cmdOp      (cmdOp),
    .cmdBank    (cmdBank),
    .bankIdle   (bankIdle),
    .bankMayRdWr(mayRdWr),
    .bankMayPre (mayPre),
    .stb        (stb)
  );

  ddr_trk_datapath #(.T_RCD(T_RCD), .T_APR(T_APR), .MAX_CAS(MAX_CAS)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .modeBurstLen(modeBurstLen),
    .modeCasLat  (modeCasLat),
    .bankIdle    (bankIdle),
    .mayRdWr     (mayRdWr),
    .mayPre      (mayPre),
    .rdDataDue   (rdDataDue),
    .cmdErr      (cmdErr)
  );
endmodule

// File: rtl/ddr_bank_tracker_chk.sv
`timescale 1ns/1ps
module ddr_bank_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cmdOp,
  input logic [1:0] cmdBank,
  input logic [1:0] modeBurstLen,
  input logic [3:0] mayRdWr,
  input logic [3:0] mayPre,
  input logic       cmdErr
);
  logic isCol, isAp, isPlain;

  always_comb begin
    isCol   = (cmdOp >= 3'd2) && (cmdOp <= 3'd5);
    isAp    = (cmdOp == 3'd4) || (cmdOp == 3'd5);
    isPlain = (cmdOp == 3'd2) || (cmdOp == 3'd3);
  end

  // R8: the error flag never drops without reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmdErr |=> cmdErr);

  // R8: a column access to a bank without permission is flagged
  p_bad_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (isCol && !mayRdWr[cmdBank]) |=> cmdErr);

  // R6: an accepted auto-precharge access locks the bank against precharge
  p_ap_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (isAp && mayRdWr[cmdBank]) |=> !mayPre[$past(cmdBank)]);

  // R4: a multi-cycle plain burst withdraws the column permission
  p_burst_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (isPlain && mayRdWr[cmdBank] && modeBurstLen[1]) |=> !mayRdWr[$past(cmdBank)]);

  generate
    for (genvar b = 0; b < 4; b++) begin : g_bank
      // R6: a locked bank never offers a column access
      p_lock_no_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mayPre[b] |-> !mayRdWr[b]);
      // R7: precharge-all closes each bank that was not locked
      p_prea_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmdOp == 3'd7 && mayPre[b]) |=> (!mayRdWr[b] && mayPre[b]));
    end
  endgenerate
endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmdOp       (cmdOp),
  .cmdBank     (cmdBank),
  .modeBurstLen(modeBurstLen),
  .mayRdWr     (mayRdWr),
  .mayPre      (mayPre),
  .cmdErr      (cmdErr)
);

// File: tb/ddr_bank_tracker_tb.sv
`timescale 1ns/1ps
module ddr_bank_tracker_tb;
  localparam int T_RCD   = 3;
  localparam int T_APR   = 2;
  localparam int MAX_CAS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [1:0] cmdBank = 2'd0;
  logic [2:0] modeCasLat = 3'd3;
  logic [1:0] modeBurstLen = 2'b10;
  logic [3:0] mayRdWr, mayPre;
  logic       rdDataDue, cmdErr;

  always #2 clk = ~clk;

  ddr_bank_tracker #(.T_RCD(T_RCD), .T_APR(T_APR), .MAX_CAS(MAX_CAS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .modeCasLat(modeCasLat), .modeBurstLen(modeBurstLen),
    .mayRdWr(mayRdWr), .mayPre(mayPre), .rdDataDue(rdDataDue), .cmdErr(cmdErr)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference: 0 closed, 1 open, 3 locked
  int st[4];
  int openAt[4];
  int freeAt[4];
  int lockEnd[4];
  int dueQ[$];
  bit errM;
  int cl;
  int beats;

  task automatic chk(string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: got %b expected %b", tag, what, cyc, act, exp);
    end
  endtask

  function automatic bit mCol(int b);
    return st[b] == 1 && cyc >= openAt[b] && cyc >= freeAt[b];
  endfunction

  task automatic compare();
    logic [3:0] eCol, ePre;
    bit eDue;
    for (int b = 0; b < 4; b++) if (st[b] == 3 && cyc >= lockEnd[b]) st[b] = 0;
    for (int b = 0; b < 4; b++) begin
      eCol[b] = mCol(b);
      ePre[b] = (st[b] != 3);
    end
    eDue = 0;
    foreach (dueQ[i]) if (dueQ[i] == cyc) eDue = 1;
    while (dueQ.size() > 0 && dueQ[0] <= cyc) void'(dueQ.pop_front());
    chk("mayRdWr", mayRdWr, eCol);
    chk("mayPre", mayPre, ePre);
    chk("rdDataDue", {3'b0, rdDataDue}, {3'b0, eDue});
    chk("cmdErr", {3'b0, cmdErr}, {3'b0, errM});
  endtask

  task automatic modelCmd(int op, int b);
    case (op)
      1: if (st[b] == 0) begin st[b] = 1; openAt[b] = cyc + T_RCD; freeAt[b] = 0; end
         else errM = 1;
      2, 3, 4, 5: begin
        if (mCol(b)) begin
          if (op == 2 || op == 3) freeAt[b] = cyc + beats;
          else begin st[b] = 3; lockEnd[b] = cyc + beats + T_APR; end
          if (op == 2 || op == 4) dueQ.push_back(cyc + cl);
        end else errM = 1;
      end
      6: if (st[b] == 3) errM = 1; else st[b] = 0;
      7: for (int k = 0; k < 4; k++) if (st[k] != 3) st[k] = 0;
      default: ;
    endcase
  endtask

  task automatic tick(int op, int b);
    compare();
    modelCmd(op, b);
    cmdOp = 3'(op);
    cmdBank = 2'(b);
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0);
  endtask

  task automatic doReset(int casIn, logic [1:0] blCode);
    rst_n = 1'b0;
    cmdOp = 3'd0;
    modeCasLat = 3'(casIn);
    modeBurstLen = blCode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    for (int b = 0; b < 4; b++) begin st[b] = 0; openAt[b] = 0; freeAt[b] = 0; lockEnd[b] = 0; end
    dueQ.delete();
    errM = 0;
    cl = (casIn < 1) ? 1 : (casIn > MAX_CAS ? MAX_CAS : casIn);
    beats = (blCode == 2'b10) ? 2 : (blCode == 2'b11 ? 4 : 1);
    tag = "R1";
    chk("reset mayRdWr", mayRdWr, 4'b0000);
    chk("reset mayPre", mayPre, 4'b1111);
    chk("reset rdDataDue", {3'b0, rdDataDue}, 4'b0);
    chk("reset cmdErr", {3'b0, cmdErr}, 4'b0);
  endtask

  task automatic randomRun(int n);
    for (int i = 0; i < n; i++) begin
      int r = int'($urandom % 16);
      tick(r < 8 ? 0 : r - 8, int'($urandom % 4));
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset(3, 2'b10);
    tag = "R10"; idle(2);
    tag = "R2";  tick(1, 0); idle(3);
    tag = "R3";  tick(2, 0); idle(4);
    tag = "R4";  tick(3, 0); idle(2);
    tag = "R5";  tick(2, 0); tick(6, 0); tick(0, 0); tick(1, 0); idle(3);
    tag = "R9";  tick(6, 3); idle(1);
    tag = "R6";  tick(1, 1); idle(2); tick(4, 1); tick(6, 1); idle(4); tick(1, 1); idle(3);
    tick(5, 1); idle(5);
    tag = "R7";  tick(1, 2); tick(1, 3); idle(3); tick(4, 2); tick(2, 3); tick(7, 0); idle(5);
    tag = "R8";  tick(2, 0); idle(1); tick(1, 0); tick(1, 0); idle(1); tick(3, 0); idle(3);

    doReset(2, 2'b11);
    tag = "R4";  tick(1, 0); idle(3); tick(3, 0); idle(5);
    tag = "R6";  tick(1, 2); idle(3); tick(4, 2); tick(7, 0); idle(8);
    tag = "R8";  randomRun(3000);

    doReset(1, 2'b01);
    tag = "R3";  tick(1, 1); idle(3); tick(2, 1); tick(2, 1); idle(3);
    tag = "R8";  randomRun(3000);

    doReset(4, 2'b00);
    tag = "R4";  tick(1, 3); idle(3); tick(2, 3); tick(3, 3); idle(5);
    tag = "R8";  randomRun(3000);

    doReset(7, 2'b10);
    tag = "R3";  tick(1, 0); idle(3); tick(4, 0); idle(8);
    tag = "R7";  randomRun(2000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule